// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This block keeps the 32-bit floating-point status and control word of a scalar core. It carries out the move-to and move-from operations on that word, accepting one command per clock. Bits and fields are numbered big-endian. Bit index 0 and field 0 sit at the most significant end, and there are eight 4-bit fields.

A command is qualified by `cmd_valid` and selected by `cmd_op`. The commands are:
- set one bit;
- clear one bit;
- copy one field to a condition-register field, then clear the sticky exception bits that field owns;
- load a 4-bit immediate into a field;
- merge fields from a wide source operand under an 8-bit field mask;
- read the word out, zero-extended.

All outputs are registered and reflect the command one clock after the edge that accepts it. A pair of pulses reports each change of the non-IEEE mode control bit.

Top module: `fpscr_unit`

## Requirements
- R1: While reset is asserted, the status word is cleared to zero and `cr_we`, `ni_on`, `ni_off` and `rd_data` are driven low.
- R2: Opcode 0 (set bit) with index n in `cmd_idx` sets word bit position 31-n, so index 0 is the most significant bit. All other bits are left unchanged.
- R3: Opcode 1 (clear bit) with index n clears word bit position 31-n. All other bits are left unchanged.
- R4: Opcode 2 (copy field) with source field k in `cmd_idx[2:0]` has the following effect one clock after the accepting edge:
  - `cr_we` is high;
  - `cr_field` equals `cmd_crf`;
  - `cr_nib` equals word bits [31-4k:28-4k] as they were before the command.

  `cr_we` is low after every other command and after idle cycles.
- R5: After a copy from field k, the following sticky bits are cleared, given here as index = 31 - bit position:
  - k=0 clears indices 0 and 3;
  - k=1 clears indices 4 to 7;
  - k=2 clears indices 8 to 11;
  - k=3 clears index 12;
  - k=5 clears indices 21, 22 and 23;
  - k=4, 6 and 7 leave the word unchanged.
- R6: Opcode 3 (immediate load) replaces the whole field `cmd_idx[2:0]` with `cmd_imm`. All other fields are left unchanged.
- R7: Opcode 4 (masked load) makes the new word `(old & ~M) | (cmd_src[31:0] & M)`. In M, bit `cmd_fmask[i]` enables word bits [4i+3:4i], which is field 7-i.
- R8: Opcode 5 (read) places the word, as it was before the command and zero-extended, on `rd_data` one clock later. `rd_data` holds its value until the next read.
- R9: A clock with `cmd_valid` low, or with opcode 6 or 7, leaves the word unchanged and raises neither `cr_we` nor a mode pulse.
- R10: Index 29 (word bit 2) is the non-IEEE mode bit. One clock after any command that changes it, exactly one of two pulses is high for one cycle:
  - `ni_on` when the bit goes from 0 to 1;
  - `ni_off` when the bit goes from 1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command qualifier |
| cmd_op | input | 3 | Opcode (0 set, 1 clear, 2 copy, 3 immediate, 4 masked load, 5 read) |
| cmd_idx | input | 5 | Bit index, or field index in bits [2:0] |
| cmd_crf | input | 3 | Destination condition-register field for a copy |
| cmd_imm | input | 4 | Immediate nibble |
| cmd_fmask | input | 8 | Field enable mask for the masked load |
| cmd_src | input | OPND_W | Source operand for the masked load |
| cr_we | output | 1 | Condition-register write strobe |
| cr_field | output | 3 | Condition-register field written |
| cr_nib | output | 4 | Nibble written to the condition register |
| rd_data | output | OPND_W | Zero-extended word from the last read |
| ni_on | output | 1 | Non-IEEE mode bit went from 0 to 1 |
| ni_off | output | 1 | Non-IEEE mode bit went from 1 to 0 |

## Verification
The bench builds the block with its defaults:
- `OPND_W` is 64, so the read zero-extension and the ignored upper half of the masked-load source are both exercised.
- `NI_IDX` is 29, which puts the mode bit in field 7.

With the mode bit in field 7, four opcodes can toggle it: set, clear, immediate load and masked load. The mode pulses are therefore reached from every opcode that can touch the bit. Random field masks and indices reach every field's sticky-clear group.

// File: rtl/fpscr_unit.sv
module fpscr_unit #(
  parameter int OPND_W = 64,
  parameter int NI_IDX = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [4:0]        cmd_idx,
  input  logic [2:0]        cmd_crf,
  input  logic [3:0]        cmd_imm,
  input  logic [7:0]        cmd_fmask,
  input  logic [OPND_W-1:0] cmd_src,
  output logic              cr_we,
  output logic [2:0]        cr_field,
  output logic [3:0]        cr_nib,
  output logic [OPND_W-1:0] rd_data,
  output logic              ni_on,
  output logic              ni_off
);
  localparam int RW     = 32;
  localparam int NF     = RW / 4;
  localparam int NI_POS = RW - 1 - NI_IDX;

  localparam logic [2:0] OP_SET  = 3'd0;
  localparam logic [2:0] OP_CLR  = 3'd1;
  localparam logic [2:0] OP_COPY = 3'd2;
  localparam logic [2:0] OP_IMM  = 3'd3;
  localparam logic [2:0] OP_MASK = 3'd4;
  localparam logic [2:0] OP_READ = 3'd5;

  logic [RW-1:0] fs_q, fs_d;
  logic [RW-1:0] bit_sel, fld_sel, merge_m, sticky_m, imm_sh;
  logic [4:0]    fld_sh;
  logic [3:0]    fld_val;

  assign fld_sh  = {~cmd_idx[2:0], 2'b00};
  assign bit_sel = 32'h8000_0000 >> cmd_idx;
  assign fld_sel = 32'h0000_000F << fld_sh;
  assign imm_sh  = {28'd0, cmd_imm} << fld_sh;
  assign fld_val = 4'(fs_q >> fld_sh);

  for (genvar i = 0; i < NF; i++) begin : g_mask
    assign merge_m[4*i +: 4] = {4{cmd_fmask[i]}};
  end

  always_comb begin
    case (cmd_idx[2:0])
      3'd0:    sticky_m = 32'h9000_0000;
      3'd1:    sticky_m = 32'h0F00_0000;
      3'd2:    sticky_m = 32'h00F0_0000;
      3'd3:    sticky_m = 32'h0008_0000;
      3'd5:    sticky_m = 32'h0000_0700;
      default: sticky_m = 32'h0000_0000;
    endcase
  end

  always_comb begin
    fs_d = fs_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_SET:  fs_d = fs_q | bit_sel;
        OP_CLR:  fs_d = fs_q & ~bit_sel;
        OP_COPY: fs_d = fs_q & ~sticky_m;
        OP_IMM:  fs_d = (fs_q & ~fld_sel) | imm_sh;
        OP_MASK: fs_d = (fs_q & ~merge_m) | (cmd_src[RW-1:0] & merge_m);
        default: fs_d = fs_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q     <= '0;
      cr_we    <= 1'b0;
      cr_field <= '0;
      cr_nib   <= '0;
      rd_data  <= '0;
      ni_on    <= 1'b0;
      ni_off   <= 1'b0;
    end else begin
      fs_q   <= fs_d;
      cr_we  <= cmd_valid && (cmd_op == OP_COPY);
      ni_on  <= !fs_q[NI_POS] && fs_d[NI_POS];
      ni_off <= fs_q[NI_POS] && !fs_d[NI_POS];
      if (cmd_valid && cmd_op == OP_COPY) begin
        cr_field <= cmd_crf;
        cr_nib   <= fld_val;
      end
      if (cmd_valid && cmd_op == OP_READ)
        rd_data <= OPND_W'(fs_q);
    end
  end
endmodule

module fpscr_unit_chk #(
  parameter int OPND_W = 64,
  parameter int NI_POS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [2:0]        cmd_crf,
  input logic              cr_we,
  input logic [2:0]        cr_field,
  input logic [OPND_W-1:0] rd_data,
  input logic              ni_on,
  input logic              ni_off,
  input logic [31:0]       fs_q
);
  p_cr_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> $past(cmd_valid && cmd_op == 3'd2));
  p_cr_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cr_we |-> cr_field == $past(cmd_crf));
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cmd_valid) |-> $stable(fs_q));
  p_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_op == 3'd5) |-> rd_data == OPND_W'($past(fs_q)));
  p_ni_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ni_on && ni_off));
  p_ni_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ni_on |-> fs_q[NI_POS] && !$past(fs_q[NI_POS]));
  p_ni_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ni_off |-> !fs_q[NI_POS] && $past(fs_q[NI_POS]));
endmodule

bind fpscr_unit fpscr_unit_chk #(.OPND_W(OPND_W), .NI_POS(NI_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_crf(cmd_crf), .cr_we(cr_we), .cr_field(cr_field), .rd_data(rd_data),
  .ni_on(ni_on), .ni_off(ni_off), .fs_q(fs_q)
);

// File: tb/fpscr_unit_tb.sv
module fpscr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  cmd_idx = '0;
  logic [2:0]  cmd_crf = '0;
  logic [3:0]  cmd_imm = '0;
  logic [7:0]  cmd_fmask = '0;
  logic [63:0] cmd_src = '0;
  logic        cr_we, ni_on, ni_off;
  logic [2:0]  cr_field;
  logic [3:0]  cr_nib;
  logic [63:0] rd_data;

  int checks = 0;
  int fails = 0;
  logic [31:0] exp_q = '0;
  logic [63:0] exp_rd = '0;

  always #4 clk = ~clk;

  fpscr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_crf(cmd_crf), .cmd_imm(cmd_imm),
    .cmd_fmask(cmd_fmask), .cmd_src(cmd_src), .cr_we(cr_we),
    .cr_field(cr_field), .cr_nib(cr_nib), .rd_data(rd_data),
    .ni_on(ni_on), .ni_off(ni_off)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sticky_of(input int k);
    case (k)
      0: return (32'h1 << 31) | (32'h1 << 28);
      1: return 32'hF << 24;
      2: return 32'hF << 20;
      3: return 32'h1 << 19;
      5: return 32'h7 << 8;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, input bit v, input logic [2:0] op,
      input logic [4:0] idx, input logic [3:0] imm, input logic [7:0] fm, input logic [63:0] src);
    logic [31:0] r = w;
    int k = int'(idx[2:0]);
    int pos;
    if (!v) return w;
    case (op)
      3'd0: r[31 - int'(idx)] = 1'b1;
      3'd1: r[31 - int'(idx)] = 1'b0;
      3'd2: r = w & ~sticky_of(k);
      3'd3: begin pos = 28 - 4*k; for (int b = 0; b < 4; b++) r[pos+b] = imm[b]; end
      3'd4: for (int i = 0; i < 8; i++) if (fm[i]) for (int b = 0; b < 4; b++) r[4*i+b] = src[4*i+b];
      default: r = w;
    endcase
    return r;
  endfunction

  task automatic cmd(input bit v, input logic [2:0] op, input logic [4:0] idx, input logic [2:0] crf,
      input logic [3:0] imm, input logic [7:0] fm, input logic [63:0] src, input string req);
    logic [31:0] old = exp_q;
    logic [31:0] nw = model(exp_q, v, op, idx, imm, fm, src);
    logic [3:0]  nib = 4'(old >> (28 - 4*int'(idx[2:0])));
    cmd_valid = v; cmd_op = op; cmd_idx = idx; cmd_crf = crf;
    cmd_imm = imm; cmd_fmask = fm; cmd_src = src;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cr_we == (v && op == 3'd2), {req, " R4 strobe"}, 64'(cr_we), 64'(v && op == 3'd2));
    if (v && op == 3'd2) begin
      chk(cr_field == crf, "R4 field", 64'(cr_field), 64'(crf));
      chk(cr_nib == nib, "R4 nibble", 64'(cr_nib), 64'(nib));
    end
    chk(ni_on == (!old[2] && nw[2]), {req, " R10 on"}, 64'(ni_on), 64'(!old[2] && nw[2]));
    chk(ni_off == (old[2] && !nw[2]), {req, " R10 off"}, 64'(ni_off), 64'(old[2] && !nw[2]));
    if (v && op == 3'd5) exp_rd = {32'd0, old};
    chk(rd_data == exp_rd, {req, " R8 read"}, rd_data, exp_rd);
    exp_q = nw;
  endtask

  task automatic rd_chk(input string req);
    cmd(1'b1, 3'd5, 5'd0, 3'd0, 4'd0, 8'd0, 64'd0, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cr_we == 0 && ni_on == 0 && ni_off == 0 && rd_data == 0, "R1 reset outputs",
        {cr_we, ni_on, ni_off}, 64'd0);
    rst_n = 1'b1;
    rd_chk("R1 reset word");

    cmd(1'b1, 3'd0, 5'd0, 0, 0, 0, 0, "R2 set msb"); rd_chk("R2");
    cmd(1'b1, 3'd0, 5'd31, 0, 0, 0, 0, "R2 set lsb"); rd_chk("R2");
    cmd(1'b1, 3'd0, 5'd29, 0, 0, 0, 0, "R10 set ni"); rd_chk("R10");
    cmd(1'b1, 3'd1, 5'd29, 0, 0, 0, 0, "R10 clr ni");
    cmd(1'b1, 3'd1, 5'd0, 0, 0, 0, 0, "R3 clear msb"); rd_chk("R3");
    cmd(1'b1, 3'd3, 5'd7, 0, 4'h4, 0, 0, "R6 imm ni"); rd_chk("R6");
    cmd(1'b1, 3'd3, 5'd2, 0, 4'hA, 0, 0, "R6 imm f2"); rd_chk("R6");
    cmd(1'b1, 3'd4, 0, 0, 0, 8'hFF, 64'hDEAD_BEEF_FFFF_FFFF, "R7 all ones"); rd_chk("R7");
    for (int k = 0; k < 8; k++) begin
      cmd(1'b1, 3'd2, 5'(k), 3'(7 - k), 0, 0, 0, "R5 copy");
      rd_chk("R5 sticky");
    end
    cmd(1'b1, 3'd4, 0, 0, 0, 8'h01, 64'h0, "R7 field7 clears ni"); rd_chk("R7");
    cmd(1'b0, 3'd0, 5'd5, 0, 0, 0, 0, "R9 idle"); rd_chk("R9");
    cmd(1'b1, 3'd6, 5'd5, 0, 4'hF, 8'hFF, 64'hFFFF_FFFF, "R9 op6");
    cmd(1'b1, 3'd7, 5'd5, 0, 4'hF, 8'hFF, 64'hFFFF_FFFF, "R9 op7"); rd_chk("R9");

    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom % 8) != 0;
      logic [2:0] op = 3'($urandom % 8);
      cmd(v, op, 5'($urandom), 3'($urandom), 4'($urandom), 8'($urandom),
          {$urandom, $urandom}, "rand");
      if (($urandom % 4) == 0) rd_chk("R8 rand");
    end
    rd_chk("R8 final");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule